// File: doc/BRIEF.md
# Programmable Pin Glitch Filter

This block cleans up one synchronised GPIO input before interrupt detection sees it. It holds a filtered copy of the pin. When the raw level moves away from that copy, the move is accepted only after the new level has stayed put for a programmed window. The window is measured in ticks of a slow real-time clock. These ticks reach the block as single-cycle enables on the system clock.

The window is set by two fields. A unit selector picks how many ticks make one unit: 2, 8, 512 or 2048 by default. A 4-bit count sets how many units, from one to sixteen. A 2-bit mode field picks one of four behaviours:
- no filtering;
- both directions filtered;
- falling changes passed at once, rising ones filtered (suits active-high level interrupts);
- rising changes passed at once, falling ones filtered (suits active-low level interrupts).

Configuration is expected to be stable while a change is pending.

Top module: `pin_glitch_filter`

## Requirements
- R1: While `rst` is high at a clock edge, `pin_out` takes the value of `pin_in` at that edge and all window progress is discarded, so the first change after reset needs a full window.
- R2: The unit length follows `unit_sel`: 0 selects UNIT0_TICKS, 1 selects UNIT1_TICKS, 2 selects UNIT2_TICKS and 3 selects UNIT3_TICKS tick enables (defaults 2, 8, 512, 2048).
- R3: A filtered change appears on `pin_out` at the clock edge that samples the N-th `tick_en` counted since `pin_in` began to differ, where N = (`win_count` + 1) × unit length, and not earlier.
- R4: `flt_mode` = 0 turns filtering off: `pin_out` equals `pin_in` one clock later, regardless of ticks.
- R5: `flt_mode` = 3 filters both rising and falling changes per R3.
- R6: `flt_mode` = 1 passes a falling change to `pin_out` one clock later, and filters rising changes per R3.
- R7: `flt_mode` = 2 passes a rising change to `pin_out` one clock later, and filters falling changes per R3.
- R8: If `pin_in` returns to the `pin_out` level before the window ends, the progress is discarded and the next change again needs N full ticks.
- R9: If `pin_in` returns to the `pin_out` level in the same cycle as the tick that would end the window, `pin_out` does not change.
- R10: Tick enables that arrive while `pin_in` equals `pin_out` have no effect on a later window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable per slow-clock tick |
| pin_in | input | 1 | Synchronised raw pin level |
| flt_mode | input | 2 | 0 off, 1 pass falling, 2 pass rising, 3 filter both |
| unit_sel | input | 2 | Ticks per unit select |
| win_count | input | CNT_W | Window length in units, minus one |
| pin_out | output | 1 | Filtered pin level |

## Verification
The case where two things fall in the same cycle is window expiry meeting a restart. The tick that completes the last unit arrives in the very cycle the input drops back to the filtered level. The bench provokes this by counting N−1 ticks and then driving the final tick and the reverted level on the same falling edge. It judges the result by requiring `pin_out` to hold, and by requiring the next change to need a whole new window. The sweep that matches each expiry to the N-th tick uses the bench's own arithmetic (count+1 times the chosen unit) over all unit selections, all counts and both directions.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

    typedef enum logic [1:0] {
        FLT_OFF       = 2'b00,
        FLT_PASS_LOW  = 2'b01,
        FLT_PASS_HIGH = 2'b10,
        FLT_BOTH      = 2'b11
    } flt_mode_e;

    typedef struct packed {
        logic differs;
        logic bypass;
        logic pending;
    } pgf_state_t;

    function automatic int pick_unit(input logic [1:0] sel,
                                     input int u0, input int u1,
                                     input int u2, input int u3);
        case (sel)
            2'd0:    return u0;
            2'd1:    return u1;
            2'd2:    return u2;
            default: return u3;
        endcase
    endfunction

    function automatic int max_unit(input int a, input int b,
                                    input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // True when a change toward level 'to_high' skips the window.
    function automatic logic is_bypass(input flt_mode_e m, input logic to_high);
        case (m)
            FLT_OFF:       return 1'b1;
            FLT_PASS_LOW:  return ~to_high;
            FLT_PASS_HIGH: return to_high;
            default:       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pgf_prescaler.sv
module pgf_prescaler
    import pgf_pkg::*;
#(
    parameter int UNIT0_TICKS = 2,
    parameter int UNIT1_TICKS = 8,
    parameter int UNIT2_TICKS = 512,
    parameter int UNIT3_TICKS = 2048
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       tick_en,
    input  logic [1:0] unit_sel,
    output logic       unit_done
);
    localparam int UMAX = max_unit(UNIT0_TICKS, UNIT1_TICKS, UNIT2_TICKS, UNIT3_TICKS);
    localparam int PW   = (UMAX > 2) ? $clog2(UMAX) : 1;

    logic [PW-1:0] pcnt;
    int            sel_len;
    logic          at_last;

    always_comb begin
        sel_len   = pick_unit(unit_sel, UNIT0_TICKS, UNIT1_TICKS, UNIT2_TICKS, UNIT3_TICKS);
        at_last   = (pcnt == PW'(sel_len - 1));
        unit_done = tick_en & at_last & ~clr;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt <= '0;
        end else if (tick_en) begin
            if (at_last) pcnt <= '0;
            else         pcnt <= pcnt + 1'b1;
        end
    end

    // R2: the tick count within a unit never reaches the selected length
    a_r2_pcnt_bound: assert property (@(posedge clk) disable iff (rst)
        int'(pcnt) < sel_len);

    // R10: idle cycles leave no tick progress behind
    a_r10_pre_idle_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> pcnt == '0);

endmodule

// File: rtl/pgf_window.sv
module pgf_window #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             unit_done,
    input  logic [CNT_W-1:0] win_count,
    output logic             expire
);
    logic [CNT_W-1:0] ucnt;

    always_comb expire = unit_done & (ucnt == win_count);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ucnt <= '0;
        end else if (unit_done) begin
            if (expire) ucnt <= '0;
            else        ucnt <= ucnt + 1'b1;
        end
    end

    // R3: the unit count stays within the programmed window
    a_r3_unit_bound: assert property (@(posedge clk) disable iff (rst)
        !clr |-> ucnt <= win_count);

    // R8: a restart discards all units counted so far
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (rst)
        clr |=> ucnt == '0);

endmodule

// File: rtl/pgf_decide.sv
module pgf_decide
    import pgf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    input  flt_mode_e mode,
    input  logic      expire,
    output logic      q,
    output logic      pending
);
    pgf_state_t st;

    always_comb begin
        st.differs = din ^ q;
        st.bypass  = is_bypass(mode, din);
        st.pending = st.differs & ~st.bypass;
        pending    = st.pending;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= din;
        end else if (st.differs && (st.bypass || expire)) begin
            q <= din;
        end
    end

    // R4: with filtering off the output tracks the input one cycle later
    a_r4_off_follows: assert property (@(posedge clk) disable iff (rst)
        (mode == FLT_OFF) |=> q == $past(din));

    // R6: a falling change passes at once in pass-low mode
    a_r6_fall_passes: assert property (@(posedge clk) disable iff (rst)
        (mode == FLT_PASS_LOW && q && !din) |=> !q);

    // R7: a rising change passes at once in pass-high mode
    a_r7_rise_passes: assert property (@(posedge clk) disable iff (rst)
        (mode == FLT_PASS_HIGH && !q && din) |=> q);

    // R5: a filtered change holds until the window expires
    a_r5_hold_pending: assert property (@(posedge clk) disable iff (rst)
        (pending && !expire) |=> $stable(q));

    // R9: with input back at the output level, nothing changes
    a_r9_settled_stable: assert property (@(posedge clk) disable iff (rst)
        !(din ^ q) |=> $stable(q));

endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter
    import pgf_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int UNIT0_TICKS = 2,
    parameter int UNIT1_TICKS = 8,
    parameter int UNIT2_TICKS = 512,
    parameter int UNIT3_TICKS = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             pin_in,
    input  logic [1:0]       flt_mode,
    input  logic [1:0]       unit_sel,
    input  logic [CNT_W-1:0] win_count,
    output logic             pin_out
);
    flt_mode_e mode;
    logic      pending;
    logic      unit_done;
    logic      expire;
    logic      q;

    always_comb mode = flt_mode_e'(flt_mode);

    pgf_prescaler #(
        .UNIT0_TICKS(UNIT0_TICKS),
        .UNIT1_TICKS(UNIT1_TICKS),
        .UNIT2_TICKS(UNIT2_TICKS),
        .UNIT3_TICKS(UNIT3_TICKS)
    ) u_pre (
        .clk       (clk),
        .rst       (rst),
        .clr       (~pending),
        .tick_en   (tick_en),
        .unit_sel  (unit_sel),
        .unit_done (unit_done)
    );

    pgf_window #(.CNT_W(CNT_W)) u_win (
        .clk       (clk),
        .rst       (rst),
        .clr       (~pending),
        .unit_done (unit_done),
        .win_count (win_count),
        .expire    (expire)
    );

    pgf_decide u_dec (
        .clk     (clk),
        .rst     (rst),
        .din     (pin_in),
        .mode    (mode),
        .expire  (expire),
        .q       (q),
        .pending (pending)
    );

    always_comb pin_out = q;

    // R3: expiry only ever fires on a counted tick
    a_r3_expire_on_tick: assert property (@(posedge clk) disable iff (rst)
        expire |-> tick_en && pending);

endmodule

// File: tb/pin_glitch_filter_tb_top.sv
module pin_glitch_filter_tb_top;

    localparam int U0 = 2, U1 = 3, U2 = 4, U3 = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       pin_in = 1'b0;
    logic [1:0] flt_mode = 2'd0;
    logic [1:0] unit_sel = 2'd0;
    logic [3:0] win_count = 4'd0;
    logic       pin_out;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pin_glitch_filter #(
        .CNT_W(4), .UNIT0_TICKS(U0), .UNIT1_TICKS(U1),
        .UNIT2_TICKS(U2), .UNIT3_TICKS(U3)
    ) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .pin_in(pin_in),
        .flt_mode(flt_mode), .unit_sel(unit_sel), .win_count(win_count),
        .pin_out(pin_out)
    );

    function automatic int ulen(input int sel);
        case (sel)
            0: return U0;
            1: return U1;
            2: return U2;
            default: return U3;
        endcase
    endfunction

    task automatic check(input logic got, input logic exp, input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick_en = 1'b1;
        @(negedge clk) tick_en = 1'b0;
    endtask

    task automatic set_in(input logic v);
        @(negedge clk) pin_in = v;
    endtask

    task automatic configure(input int mode, input int sel, input int cnt);
        @(negedge clk);
        flt_mode  = 2'(mode);
        unit_sel  = 2'(sel);
        win_count = 4'(cnt);
    endtask

    // Drives a filtered change and checks it lands exactly on tick N.
    task automatic window_run(input int mode, input int sel, input int cnt,
                              input logic v, input string req);
        int n;
        configure(mode, sel, cnt);
        n = (cnt + 1) * ulen(sel);
        set_in(v);
        for (int k = 1; k < n; k++) pulse_tick();
        check(pin_out, ~v, req, "held before last tick");
        pulse_tick();
        check(pin_out, v, req, "changed on last tick");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset loads the input level
        pin_in = 1'b1;
        repeat (3) @(negedge clk);
        check(pin_out, 1'b1, "R1", "reset with input high");
        pin_in = 1'b0;
        repeat (2) @(negedge clk);
        check(pin_out, 1'b0, "R1", "reset with input low");
        rst = 1'b0;

        // R4: filtering off follows one clock later, ticks irrelevant
        configure(0, 3, 15);
        set_in(1'b1);
        @(negedge clk);
        check(pin_out, 1'b1, "R4", "off rising");
        set_in(1'b0);
        @(negedge clk);
        check(pin_out, 1'b0, "R4", "off falling");

        // R2 R3 R5: every unit, every count, both directions
        for (int sel = 0; sel < 4; sel++) begin
            for (int cnt = 0; cnt < 16; cnt++) begin
                window_run(3, sel, cnt, 1'b1, "R3");
                window_run(3, sel, cnt, 1'b0, "R5");
            end
        end

        // R6: rising filtered, falling passes at once
        window_run(1, 1, 2, 1'b1, "R6");
        set_in(1'b0);
        @(negedge clk);
        check(pin_out, 1'b0, "R6", "falling passes");
        window_run(1, 0, 0, 1'b1, "R6");

        // R7: falling filtered, rising passes at once
        window_run(2, 2, 1, 1'b0, "R7");
        set_in(1'b1);
        @(negedge clk);
        check(pin_out, 1'b1, "R7", "rising passes");
        window_run(2, 0, 3, 1'b0, "R7");

        // R8: early return discards progress
        configure(3, 0, 3);
        set_in(1'b1);
        for (int k = 1; k < 8; k++) pulse_tick();
        set_in(1'b0);
        @(negedge clk);
        check(pin_out, 1'b0, "R8", "glitch rejected");
        set_in(1'b1);
        for (int k = 1; k < 8; k++) pulse_tick();
        check(pin_out, 1'b0, "R8", "restart needs full window");
        pulse_tick();
        check(pin_out, 1'b1, "R8", "change after full window");

        // R9: revert in the same cycle as the final tick
        configure(3, 1, 1);
        set_in(1'b0);
        for (int k = 1; k < 6; k++) pulse_tick();
        @(negedge clk);
        tick_en = 1'b1;
        pin_in  = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        check(pin_out, 1'b1, "R9", "collision keeps level");
        pulse_tick();
        check(pin_out, 1'b1, "R9", "still held");
        window_run(3, 1, 1, 1'b0, "R9");

        // R10: idle ticks are not banked
        configure(3, 0, 2);
        for (int k = 0; k < 20; k++) pulse_tick();
        check(pin_out, 1'b0, "R10", "idle ticks");
        window_run(3, 0, 2, 1'b1, "R10");

        // R1: reset during a pending change, counters cleared
        configure(3, 0, 1);
        set_in(1'b0);
        for (int k = 0; k < 3; k++) pulse_tick();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check(pin_out, 1'b0, "R1", "reset mid-window loads input");
        window_run(3, 0, 1, 1'b1, "R1");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule